// File: doc/BRIEF.md
# Bidirectional Matrix Scanner with Centred Black Border

This block holds the digital addressing logic of a matrix display. A horizontal scanner walks a one-hot select across 86 column groups, each 12 adjacent dots wide, which covers 1032 dots including the shielded edges. A vertical scanner walks a one-hot select down 772 rows. Both scanners are start-pulse shift registers that advance on a step strobe. A direction input picks the order for each scanner. The row select reaches the gate lines only while a row-enable input is high.

A mode stage shrinks the active window to suit the incoming picture format and keeps it centred. The width pin can narrow the line to 960 active dots. The scan then covers only the 80 middle groups, and the 3 groups on each side are flagged black. The height pin can narrow the frame to 640 active rows. A black flag is then raised whenever the selected row lies in the masked bands or the external blanking input is low.

All strobes are sampled on the rising edge of a single clock. A step with start high loads the first stage. A step without start shifts the select by one stage.

Top module: `scan_mask_top`

## Requirements
- R1: After reset, groupSel and rowGate are all zero.
- R2: A cycle with hStep and hStart high loads groupSel with the first group of the scan. That group is bit 0 when hDirNorm=1 and bit 85 when hDirNorm=0 in full width (widthFull=1). It is bit 3 and bit 82 respectively in narrow width (widthFull=0).
- R3: Each cycle with hStep high and hStart low moves the select one bit: upward when hDirNorm=1, downward when hDirNorm=0. In full width a line lasts 86 steps, after which groupSel is zero.
- R4: In narrow width the scan lasts 80 steps and visits only groups 3 to 82. groupBlank then has bits 0-2 and 83-85 set. In full width groupBlank is zero.
- R5: A start during a running scan reloads the first group of the current direction.
- R6: vStep with vStart high selects row 0 (vDirNorm=1) or row 771 (vDirNorm=0). Each later vStep moves one row, and after 772 steps no row is selected.
- R7: rowGate shows the selected row only while rowEn is high. It is all zero while rowEn is low.
- R8: With heightFull=0, rowBlank is high when the selected row is in 0-65 or 706-771, or when blankN is low. It is low for rows 66-705 while blankN is high.
- R9: With heightFull=1, rowBlank stays low whatever blankN and the row are.
- R10: groupSel and rowGate never have more than one bit set. A cycle without hStep leaves groupSel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hStart | input | 1 | Horizontal start pulse, sampled with hStep |
| hStep | input | 1 | Horizontal advance strobe |
| hDirNorm | input | 1 | 1 = normal (ascending) horizontal order |
| vStart | input | 1 | Vertical start pulse, sampled with vStep |
| vStep | input | 1 | Vertical advance strobe |
| vDirNorm | input | 1 | 1 = normal (ascending) vertical order |
| widthFull | input | 1 | 1 = 1032-dot line, 0 = 960-dot centred window |
| heightFull | input | 1 | 1 = full height, 0 = 640-row centred window |
| blankN | input | 1 | Active-low external blanking, used in narrow height |
| rowEn | input | 1 | Row gate enable |
| groupSel | output | 86 | One-hot column-group select |
| groupBlank | output | 86 | Per-group force-black flags |
| rowGate | output | 772 | One-hot gated row select |
| rowBlank | output | 1 | Force-black flag for the selected row |

## Verification
The hardest state to reach from the ports is the last stage of a long scan. Two cases matter: the edge of the 80-group window in narrow width, where the shift must empty instead of entering a masked group, and the 706th row boundary of the height band. The stimulus holds the step strobe high for entire lines and frames, in both directions and in both modes. It tracks the expected position on every step, so every boundary crossing and the final clearing are observed at the outputs.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic fwd;
  } stepCtl_t;
endpackage

// File: rtl/scan_shift.sv
module scan_shift
  import scan_pkg::*;
#(
  parameter int STAGES = 86,
  parameter int TRIM   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic              narrow,
  output logic [STAGES-1:0] q
);
  localparam int LO = TRIM;
  localparam int HI = STAGES - 1 - TRIM;

  logic [STAGES-1:0] keep;
  logic [STAGES-1:0] seed;
  logic [STAGES-1:0] shifted;

  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      keep[i] = !narrow || ((i >= LO) && (i <= HI));
      if (ctl.fwd) seed[i] = (i == (narrow ? LO : 0));
      else         seed[i] = (i == (narrow ? HI : STAGES - 1));
    end
    if (ctl.fwd) shifted = {q[STAGES-2:0], 1'b0};
    else         shifted = {1'b0, q[STAGES-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)          q <= '0;
    else if (ctl.load)  q <= seed;
    else if (ctl.shift) q <= shifted & keep;
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int NGRP     = 86,
  parameter int SIDE_GRP = 3,
  parameter int NROWS    = 772,
  parameter int BAND     = 66
) (
  input  logic             hStart,
  input  logic             hStep,
  input  logic             hDirNorm,
  input  logic             vStart,
  input  logic             vStep,
  input  logic             vDirNorm,
  input  logic             widthFull,
  input  logic             heightFull,
  input  logic             blankN,
  input  logic [NROWS-1:0] rowQ,
  output stepCtl_t         hCtl,
  output stepCtl_t         vCtl,
  output logic             hNarrow,
  output logic [NGRP-1:0]  groupBlank,
  output logic             rowBlank
);
  logic [NGRP-1:0]  edgeMask;
  logic [NROWS-1:0] bandMask;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : gEdge
      assign edgeMask[g] = (g < SIDE_GRP) || (g >= NGRP - SIDE_GRP);
    end
    for (g = 0; g < NROWS; g++) begin : gBand
      assign bandMask[g] = (g < BAND) || (g >= NROWS - BAND);
    end
  endgenerate

  always_comb begin
    hCtl.load  = hStep & hStart;
    hCtl.shift = hStep & ~hStart;
    hCtl.fwd   = hDirNorm;
    vCtl.load  = vStep & vStart;
    vCtl.shift = vStep & ~vStart;
    vCtl.fwd   = vDirNorm;
    hNarrow    = ~widthFull;
    groupBlank = hNarrow ? edgeMask : '0;
    rowBlank   = ~heightFull & ((|(rowQ & bandMask)) | ~blankN);
  end
endmodule

// File: rtl/scan_mask_top.sv
module scan_mask_top
  import scan_pkg::*;
#(
  parameter int H_DOTS   = 1032,
  parameter int GRP_DOTS = 12,
  parameter int H_BORDER = 4,
  parameter int H_TRIM   = 32,
  parameter int V_ROWS   = 772,
  parameter int V_BORDER = 2,
  parameter int V_TRIM   = 64,
  localparam int NGRP     = H_DOTS / GRP_DOTS,
  localparam int SIDE_GRP = (H_BORDER + H_TRIM) / GRP_DOTS,
  localparam int BAND     = V_BORDER + V_TRIM
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hStart,
  input  logic              hStep,
  input  logic              hDirNorm,
  input  logic              vStart,
  input  logic              vStep,
  input  logic              vDirNorm,
  input  logic              widthFull,
  input  logic              heightFull,
  input  logic              blankN,
  input  logic              rowEn,
  output logic [NGRP-1:0]   groupSel,
  output logic [NGRP-1:0]   groupBlank,
  output logic [V_ROWS-1:0] rowGate,
  output logic              rowBlank
);
  stepCtl_t          hCtl, vCtl;
  logic              hNarrow;
  logic [V_ROWS-1:0] rowQ;

  scan_ctrl #(.NGRP(NGRP), .SIDE_GRP(SIDE_GRP), .NROWS(V_ROWS), .BAND(BAND)) u_ctrl (
    .hStart(hStart), .hStep(hStep), .hDirNorm(hDirNorm),
    .vStart(vStart), .vStep(vStep), .vDirNorm(vDirNorm),
    .widthFull(widthFull), .heightFull(heightFull), .blankN(blankN),
    .rowQ(rowQ), .hCtl(hCtl), .vCtl(vCtl), .hNarrow(hNarrow),
    .groupBlank(groupBlank), .rowBlank(rowBlank)
  );

  scan_shift #(.STAGES(NGRP), .TRIM(SIDE_GRP)) u_hScan (
    .clk(clk), .rstN(rstN), .ctl(hCtl), .narrow(hNarrow), .q(groupSel)
  );

  scan_shift #(.STAGES(V_ROWS), .TRIM(0)) u_vScan (
    .clk(clk), .rstN(rstN), .ctl(vCtl), .narrow(1'b0), .q(rowQ)
  );

  assign rowGate = rowEn ? rowQ : '0;
endmodule

// File: rtl/scan_mask_chk.sv
module scan_mask_chk #(
  parameter int NGRP  = 86,
  parameter int NROWS = 772
) (
  input logic             clk,
  input logic             rstN,
  input logic             hStart,
  input logic             hStep,
  input logic             hDirNorm,
  input logic             widthFull,
  input logic             heightFull,
  input logic             rowEn,
  input logic [NGRP-1:0]  groupSel,
  input logic [NROWS-1:0] rowGate,
  input logic             rowBlank
);
  // R10
  grp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(groupSel));
  // R10
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(rowGate));
  // R10
  grp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hStep |=> $stable(groupSel));
  // R7
  row_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rowEn |-> (rowGate == '0));
  // R9
  full_height_chk: assert property (@(posedge clk) disable iff (!rstN)
    heightFull |-> !rowBlank);
  // R2
  full_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hStep && hStart && widthFull && hDirNorm) |=> groupSel[0]);
  // R4
  narrow_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hStep && hStart && !widthFull && !hDirNorm) |=> groupSel[NGRP-4]);
endmodule

bind scan_mask_top scan_mask_chk #(.NGRP(NGRP), .NROWS(V_ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .hStart(hStart), .hStep(hStep), .hDirNorm(hDirNorm),
  .widthFull(widthFull), .heightFull(heightFull), .rowEn(rowEn),
  .groupSel(groupSel), .rowGate(rowGate), .rowBlank(rowBlank)
);

// File: tb/scan_mask_top_bench.sv
module scan_mask_top_bench;
  localparam int NG = 86;
  localparam int NR = 772;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hStart = 0, hStep = 0, hDirNorm = 1;
  logic vStart = 0, vStep = 0, vDirNorm = 1;
  logic widthFull = 1, heightFull = 1, blankN = 1, rowEn = 1;
  logic [NG-1:0] groupSel, groupBlank;
  logic [NR-1:0] rowGate;
  logic rowBlank;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scan_mask_top u_scan_mask_top (
    .clk(clk), .rstN(rstN), .hStart(hStart), .hStep(hStep), .hDirNorm(hDirNorm),
    .vStart(vStart), .vStep(vStep), .vDirNorm(vDirNorm),
    .widthFull(widthFull), .heightFull(heightFull), .blankN(blankN), .rowEn(rowEn),
    .groupSel(groupSel), .groupBlank(groupBlank), .rowGate(rowGate), .rowBlank(rowBlank)
  );

  function automatic logic [NG-1:0] gBit(input int i);
    logic [NG-1:0] v = '0;
    if (i >= 0 && i < NG) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [NR-1:0] rBit(input int i);
    logic [NR-1:0] v = '0;
    if (i >= 0 && i < NR) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chkG(input string req, input logic [NG-1:0] act, input logic [NG-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkR(input string req, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkB(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R2 R3 R4: one full line in the given direction and width
  task automatic runLine(input logic dirN, input logic narrow);
    int lo = narrow ? 3 : 0;
    int hi = narrow ? 82 : 85;
    int n = hi - lo + 1;
    int pos;
    logic [NG-1:0] edges = '0;
    for (int i = 0; i < NG; i++) if (narrow && (i < 3 || i > 82)) edges[i] = 1'b1;
    widthFull = !narrow; hDirNorm = dirN; hStart = 1; hStep = 1;
    tick();
    hStart = 0;
    pos = dirN ? lo : hi;
    chkG("R2", groupSel, gBit(pos));
    chkG("R4", groupBlank, edges);
    for (int k = 1; k <= n; k++) begin
      tick();
      pos = dirN ? pos + 1 : pos - 1;
      chkG(narrow ? "R4" : "R3", groupSel, (k < n) ? gBit(pos) : '0);
    end
    hStep = 0;
  endtask

  // R6 R8: one full frame in the given direction and height
  task automatic runFrame(input logic dirN, input logic narrow);
    int pos;
    heightFull = !narrow; vDirNorm = dirN; vStart = 1; vStep = 1; rowEn = 1; blankN = 1;
    tick();
    vStart = 0;
    pos = dirN ? 0 : NR - 1;
    chkR("R6", rowGate, rBit(pos));
    for (int k = 1; k <= NR; k++) begin
      if (narrow) chkB("R8", rowBlank, (pos < 66) || (pos > 705));
      tick();
      pos = dirN ? pos + 1 : pos - 1;
      chkR("R6", rowGate, (k < NR) ? rBit(pos) : '0);
    end
    vStep = 0;
  endtask

  task automatic testReset();
    chkG("R1", groupSel, '0);
    chkR("R1", rowGate, '0);
  endtask

  task automatic testRestartHold();
    widthFull = 1; hDirNorm = 1; hStart = 1; hStep = 1;
    tick();
    hStart = 0;
    repeat (5) tick();
    chkG("R3", groupSel, gBit(5));
    hStart = 1;
    tick();
    chkG("R5", groupSel, gBit(0));
    hStart = 0; hStep = 0;
    tick(); tick();
    chkG("R10", groupSel, gBit(0));
    hDirNorm = 0; hStep = 1; hStart = 0;
    tick();
    hStep = 0;
    chkG("R10", groupSel, '0);
  endtask

  task automatic testGateAndBlank();
    heightFull = 1; vDirNorm = 1; vStart = 1; vStep = 1; rowEn = 0;
    tick();
    vStart = 0;
    repeat (99) tick();
    vStep = 0;
    chkR("R7", rowGate, '0);
    rowEn = 1; #1;
    chkR("R7", rowGate, rBit(99));
    blankN = 0; #1;
    chkB("R9", rowBlank, 1'b0);
    heightFull = 0; #1;
    chkB("R8", rowBlank, 1'b1);
    blankN = 1; #1;
    chkB("R8", rowBlank, 1'b0);
    heightFull = 1; #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    testReset();
    rstN = 1;
    tick();
    runLine(1'b1, 1'b0);
    runLine(1'b0, 1'b0);
    runLine(1'b1, 1'b1);
    runLine(1'b0, 1'b1);
    testRestartHold();
    runFrame(1'b1, 1'b0);
    runFrame(1'b0, 1'b1);
    testGateAndBlank();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule